// File: doc/BRIEF.md
# Edge-Detecting General-Purpose I/O Bank

This block is one bank of general-purpose I/O lines. It has a simple memory-mapped register port with address, write data, write enable, read enable and read data. Software sets the direction and the output level of each line. It does this only through paired set and clear strobe registers, where each one bit in a write acts on its line and each zero bit has no effect. Read-modify-write is never needed. Readback registers show the current direction, output latch, edge enables and interrupt mask.

Pin inputs pass through a synchroniser before they are sampled. The synchronised level can be read at any time. Each line has its own rising-edge enable and falling-edge enable. A detected edge is latched in a status register, and software clears that register by writing ones.

The bank drives a pending-interrupt output whenever a latched event is present on a line whose mask bit is set. Several banks can OR this output onto one shared interrupt line.

Top module: `gpio_bank_top`

## Requirements
- R1: After reset all lines are inputs (pinOe = 0). The output latch, both edge-enable registers, the status register and the mask register all read 0, and irqPending is 0.
- R2: Writing to word address 5 sets the output-latch bits that are one in the written data. Writing to address 6 clears them. Zero bits leave their lines unchanged. The latch reads back at address 4 and drives pinOut.
- R3: Writing ones to address 2 makes those lines outputs. Writing ones to address 3 makes them inputs. The direction reads back at address 1, with 1 meaning output, and it drives pinOe.
- R4: The output latch keeps its value while a line is an input and is unaffected by direction writes. A line switched to output drives the previously set latch value at once.
- R5: Address 0 returns the pin levels after a two-flop synchroniser. A pin change made just before clock edge A appears in a read captured at the third rising edge counting A. Reads capture on the edge where read enable is high and are valid from then until the next read.
- R6: Edge enables use address 8 (set) and 9 (clear) for rising edges, readback at 7. They use address 11 (set) and 12 (clear) for falling edges, readback at 10. An edge on a line whose enable for that direction is 0 is not latched.
- R7: Both edge enables can be active on one line, and then both rising and falling edges are latched.
- R8: The edge-status register reads at address 13. Writing to address 13 clears exactly the status bits written as one.
- R9: An edge detected in the same cycle as a clear of its status bit leaves the bit set.
- R10: The interrupt mask sets at address 15, clears at address 16 and reads at 14, with 1 meaning unmasked. irqPending is high exactly when some status bit is set together with its mask bit. The mask does not stop events from being latched.
- R11: Writes to unmapped addresses change no register. Reads of unmapped or write-only addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (5) | Word address of the register access |
| wrData | input | NUM_LINES (32) | Write data, one bit per line |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe, data captured on this edge |
| rdData | output | NUM_LINES (32) | Registered read data |
| pinIn | input | NUM_LINES (32) | Asynchronous pin levels |
| pinOut | output | NUM_LINES (32) | Output latch towards the pads |
| pinOe | output | NUM_LINES (32) | Output enable per line |
| irqPending | output | 1 | Unmasked latched event present |

## Verification
The bench aims at a status clear that lands in the same cycle as a new edge on that bit. A design that lets the clear win loses the event, and the read of address 13 comes back 0. It times level reads to the exact synchroniser depth, so a missing or extra flop stage shows up as the wrong read at the boundary edge. It clears one status bit while a neighbour stays set, which exposes any clear that zeroes the whole register. It also changes direction around a preset latch, which catches a design that resets the latch when a line becomes an input. The mask is toggled over a pending event to show that the interrupt follows the mask while the status keeps the event.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int REG_ADDR_W = 5;

  // word addresses of the register file
  localparam logic [REG_ADDR_W-1:0] ADR_LEVEL    = 5'd0;
  localparam logic [REG_ADDR_W-1:0] ADR_DIR      = 5'd1;
  localparam logic [REG_ADDR_W-1:0] ADR_DIR_SET  = 5'd2;
  localparam logic [REG_ADDR_W-1:0] ADR_DIR_CLR  = 5'd3;
  localparam logic [REG_ADDR_W-1:0] ADR_OUT      = 5'd4;
  localparam logic [REG_ADDR_W-1:0] ADR_OUT_SET  = 5'd5;
  localparam logic [REG_ADDR_W-1:0] ADR_OUT_CLR  = 5'd6;
  localparam logic [REG_ADDR_W-1:0] ADR_RISE     = 5'd7;
  localparam logic [REG_ADDR_W-1:0] ADR_RISE_SET = 5'd8;
  localparam logic [REG_ADDR_W-1:0] ADR_RISE_CLR = 5'd9;
  localparam logic [REG_ADDR_W-1:0] ADR_FALL     = 5'd10;
  localparam logic [REG_ADDR_W-1:0] ADR_FALL_SET = 5'd11;
  localparam logic [REG_ADDR_W-1:0] ADR_FALL_CLR = 5'd12;
  localparam logic [REG_ADDR_W-1:0] ADR_STAT    = 5'd13;
  localparam logic [REG_ADDR_W-1:0] ADR_MASK     = 5'd14;
  localparam logic [REG_ADDR_W-1:0] ADR_MASK_SET = 5'd15;
  localparam logic [REG_ADDR_W-1:0] ADR_MASK_CLR = 5'd16;

  typedef struct packed {
    logic dirSet;
    logic dirClr;
    logic outSet;
    logic outClr;
    logic riseSet;
    logic riseClr;
    logic fallSet;
    logic fallClr;
    logic statClr;
    logic maskSet;
    logic maskClr;
  } wrStrobe_t;

  localparam int STROBE_W = $bits(wrStrobe_t);

  typedef enum logic [2:0] {
    RD_NONE,
    RD_LEVEL,
    RD_DIR,
    RD_OUT,
    RD_RISE,
    RD_FALL,
    RD_STAT,
    RD_MASK
  } rdSel_e;

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] qOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stageQ[s] <= '0;
    end else begin
      stageQ[0] <= dIn;
      for (int s = 1; s < STAGES; s++) stageQ[s] <= stageQ[s-1];
    end
  end

  assign qOut = stageQ[STAGES-1];

  initial begin
    a_r5_sync_depth : assert (STAGES >= 2)
      else $error("synchroniser needs at least two stages");
  end

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output wrStrobe_t         stb,
  output rdSel_e            rdSel,
  output logic              rdStb
);

  function automatic logic hit(input logic [ADDR_W-1:0] a,
                               input logic [REG_ADDR_W-1:0] r);
    return a == ADDR_W'(r);
  endfunction

  always_comb begin
    stb         = '0;
    stb.dirSet  = wrEn && hit(addr, ADR_DIR_SET);
    stb.dirClr  = wrEn && hit(addr, ADR_DIR_CLR);
    stb.outSet  = wrEn && hit(addr, ADR_OUT_SET);
    stb.outClr  = wrEn && hit(addr, ADR_OUT_CLR);
    stb.riseSet = wrEn && hit(addr, ADR_RISE_SET);
    stb.riseClr = wrEn && hit(addr, ADR_RISE_CLR);
    stb.fallSet = wrEn && hit(addr, ADR_FALL_SET);
    stb.fallClr = wrEn && hit(addr, ADR_FALL_CLR);
    stb.statClr = wrEn && hit(addr, ADR_STAT);
    stb.maskSet = wrEn && hit(addr, ADR_MASK_SET);
    stb.maskClr = wrEn && hit(addr, ADR_MASK_CLR);
  end

  always_comb begin
    rdSel = RD_NONE;
    if (hit(addr, ADR_LEVEL))     rdSel = RD_LEVEL;
    else if (hit(addr, ADR_DIR))  rdSel = RD_DIR;
    else if (hit(addr, ADR_OUT))  rdSel = RD_OUT;
    else if (hit(addr, ADR_RISE)) rdSel = RD_RISE;
    else if (hit(addr, ADR_FALL)) rdSel = RD_FALL;
    else if (hit(addr, ADR_STAT)) rdSel = RD_STAT;
    else if (hit(addr, ADR_MASK)) rdSel = RD_MASK;
  end

  assign rdStb = rdEn;

  logic [STROBE_W-1:0] stbVec;
  assign stbVec = stb;

  // R11: at most one strobe per access, none without a write
  a_r11_one_strobe : assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stbVec));
  a_r11_no_write_no_strobe : assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (stbVec == '0));

endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wrStrobe_t            stb,
  input  rdSel_e               rdSel,
  input  logic                 rdStb,
  input  logic [NUM_LINES-1:0] wrData,
  input  logic [NUM_LINES-1:0] pinIn,
  output logic [NUM_LINES-1:0] rdData,
  output logic [NUM_LINES-1:0] pinOut,
  output logic [NUM_LINES-1:0] pinOe,
  output logic                 irqPending
);

  logic [NUM_LINES-1:0] pinSync;
  logic [NUM_LINES-1:0] levelPrev;
  logic [NUM_LINES-1:0] dirQ, outQ, riseEnQ, fallEnQ, statQ, maskQ;
  logic [NUM_LINES-1:0] riseEvt, fallEvt, evt, statClrBits;

  gpio_bank_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (pinIn),
    .qOut (pinSync)
  );

  assign riseEvt     = pinSync & ~levelPrev & riseEnQ;
  assign fallEvt     = ~pinSync & levelPrev & fallEnQ;
  assign evt         = riseEvt | fallEvt;
  assign statClrBits = stb.statClr ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) levelPrev <= '0;
    else       levelPrev <= pinSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ <= '0;
    end else if (stb.dirSet) begin
      dirQ <= dirQ | wrData;
    end else if (stb.dirClr) begin
      dirQ <= dirQ & ~wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ <= '0;
    end else if (stb.outSet) begin
      outQ <= outQ | wrData;
    end else if (stb.outClr) begin
      outQ <= outQ & ~wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseEnQ <= '0;
    end else if (stb.riseSet) begin
      riseEnQ <= riseEnQ | wrData;
    end else if (stb.riseClr) begin
      riseEnQ <= riseEnQ & ~wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fallEnQ <= '0;
    end else if (stb.fallSet) begin
      fallEnQ <= fallEnQ | wrData;
    end else if (stb.fallClr) begin
      fallEnQ <= fallEnQ & ~wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
    end else if (stb.maskSet) begin
      maskQ <= maskQ | wrData;
    end else if (stb.maskClr) begin
      maskQ <= maskQ & ~wrData;
    end
  end

  // new events win over a simultaneous clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statQ <= '0;
    else       statQ <= (statQ & ~statClrBits) | evt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (rdStb) begin
      case (rdSel)
        RD_LEVEL: rdData <= pinSync;
        RD_DIR:   rdData <= dirQ;
        RD_OUT:   rdData <= outQ;
        RD_RISE:  rdData <= riseEnQ;
        RD_FALL:  rdData <= fallEnQ;
        RD_STAT:  rdData <= statQ;
        RD_MASK:  rdData <= maskQ;
        default:  rdData <= '0;
      endcase
    end
  end

  assign pinOut     = outQ;
  assign pinOe      = dirQ;
  assign irqPending = |(statQ & maskQ);

  a_r2_set_reaches_latch : assert property (@(posedge clk) disable iff (!rstN)
    stb.outSet |=> ((pinOut & $past(wrData)) == $past(wrData)));
  a_r2_clr_reaches_latch : assert property (@(posedge clk) disable iff (!rstN)
    stb.outClr |=> ((pinOut & $past(wrData)) == '0));
  a_r4_latch_holds : assert property (@(posedge clk) disable iff (!rstN)
    !(stb.outSet || stb.outClr) |=> $stable(pinOut));
  a_r3_oe_holds : assert property (@(posedge clk) disable iff (!rstN)
    !(stb.dirSet || stb.dirClr) |=> $stable(pinOe));
  a_r6_no_spurious_event : assert property (@(posedge clk) disable iff (!rstN)
    (riseEnQ == '0 && fallEnQ == '0) |=> ((statQ & ~$past(statQ)) == '0));
  a_r9_event_survives_clear : assert property (@(posedge clk) disable iff (!rstN)
    (evt != '0) |=> ((statQ & $past(evt)) == $past(evt)));
  a_r10_irq_needs_mask : assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> !irqPending);
  a_r10_irq_needs_status : assert property (@(posedge clk) disable iff (!rstN)
    irqPending |-> (statQ != '0));

endmodule

// File: rtl/gpio_bank_top.sv
module gpio_bank_top
  import gpio_bank_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int ADDR_W      = REG_ADDR_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_LINES-1:0] wrData,
  input  logic                 wrEn,
  input  logic                 rdEn,
  output logic [NUM_LINES-1:0] rdData,
  input  logic [NUM_LINES-1:0] pinIn,
  output logic [NUM_LINES-1:0] pinOut,
  output logic [NUM_LINES-1:0] pinOe,
  output logic                 irqPending
);

  wrStrobe_t stb;
  rdSel_e    rdSel;
  logic      rdStb;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .addr  (addr),
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .stb   (stb),
    .rdSel (rdSel),
    .rdStb (rdStb)
  );

  gpio_bank_dp #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .rdSel      (rdSel),
    .rdStb      (rdStb),
    .wrData     (wrData),
    .pinIn      (pinIn),
    .rdData     (rdData),
    .pinOut     (pinOut),
    .pinOe      (pinOe),
    .irqPending (irqPending)
  );

endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_top_tb_top;

  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [4:0]    addr = '0;
  logic [N-1:0]  wrData = '0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [N-1:0]  rdData;
  logic [N-1:0]  pinIn = '0;
  logic [N-1:0]  pinOut;
  logic [N-1:0]  pinOe;
  logic          irqPending;

  int checks = 0;
  int failures = 0;
  logic [N-1:0] expQ[$];
  string        tagQ[$];

  always #5 clk = ~clk;

  gpio_bank_top dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .irqPending(irqPending)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: called just after a falling edge
  task automatic wr(input logic [4:0] a, input logic [N-1:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [N-1:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare each captured read at the following falling edge
  initial begin
    forever begin
      @(posedge clk);
      if (rdEn) begin
        @(negedge clk);
        if (expQ.size() == 0) begin
          checks++; failures++;
          $display("FAIL monitor unexpected read actual=%h expected=none", rdData);
        end else begin
          check(tagQ.pop_front(), rdData, expQ.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pinOe", pinOe, '0);
    check("R1 pinOut", pinOut, '0);
    check("R1 irq", {31'd0, irqPending}, '0);
    rd(5'd1, '0, "R1 dir");
    rd(5'd4, '0, "R1 out");
    rd(5'd7, '0, "R1 rise");
    rd(5'd10, '0, "R1 fall");
    rd(5'd13, '0, "R1 stat");
    rd(5'd14, '0, "R1 mask");

    // R2 output latch set / clear
    wr(5'd5, 32'h0000_00F0);
    rd(5'd4, 32'h0000_00F0, "R2 set");
    wr(5'd5, 32'h0F00_0000);
    rd(5'd4, 32'h0F00_00F0, "R2 second set keeps others");
    wr(5'd6, 32'h0000_0030);
    rd(5'd4, 32'h0F00_00C0, "R2 clear");
    wr(5'd6, 32'h0);
    rd(5'd4, 32'h0F00_00C0, "R2 zero clear no effect");
    check("R2 pinOut", pinOut, 32'h0F00_00C0);

    // R3 direction set / clear
    wr(5'd2, 32'h0000_FF00);
    rd(5'd1, 32'h0000_FF00, "R3 dir set");
    check("R3 pinOe set", pinOe, 32'h0000_FF00);
    wr(5'd3, 32'h0000_0F00);
    rd(5'd1, 32'h0000_F000, "R3 dir clear");
    check("R3 pinOe clear", pinOe, 32'h0000_F000);

    // R4 latch preserved across direction changes
    wr(5'd2, 32'h0000_0040);
    check("R4 drive preset level", pinOut & pinOe & 32'h40, 32'h40);
    wr(5'd3, 32'h0000_0040);
    rd(5'd4, 32'h0F00_00C0, "R4 latch kept as input");
    check("R4 oe off", pinOe & 32'h40, '0);

    // R5 synchroniser latency
    pinIn = 32'hA5A5_0000;
    rd(5'd0, 32'h0, "R5 level edge A");
    rd(5'd0, 32'h0, "R5 level edge B");
    rd(5'd0, 32'hA5A5_0000, "R5 level edge C");
    idle(3);
    rd(5'd13, '0, "R6 no event with enables off");

    // R6 per-direction enables
    wr(5'd8, 32'h1);
    wr(5'd11, 32'h2);
    rd(5'd7, 32'h1, "R6 rise enable");
    rd(5'd10, 32'h2, "R6 fall enable");
    pinIn[1:0] = 2'b11;
    idle(4);
    rd(5'd13, 32'h1, "R6 rise latched only where enabled");
    wr(5'd13, 32'h1);
    rd(5'd13, 32'h0, "R8 clear");
    pinIn[1:0] = 2'b00;
    idle(4);
    rd(5'd13, 32'h2, "R6 fall latched only where enabled");

    // R7 both edges on one line, R8 selective clear
    wr(5'd8, 32'h4);
    wr(5'd11, 32'h4);
    pinIn[2] = 1'b1;
    idle(4);
    rd(5'd13, 32'h6, "R7 rise on dual line");
    wr(5'd13, 32'h4);
    rd(5'd13, 32'h2, "R8 only written bit cleared");
    pinIn[2] = 1'b0;
    idle(4);
    rd(5'd13, 32'h6, "R7 fall on dual line");
    wr(5'd9, 32'h1);
    rd(5'd7, 32'h4, "R6 rise enable clear");
    wr(5'd13, 32'h2);
    rd(5'd13, 32'h4, "R8 bit2 left");

    // R9 clear coincides with a new edge on the same bit
    pinIn[2] = 1'b1;
    idle(2);
    wr(5'd13, 32'h4);
    rd(5'd13, 32'h4, "R9 edge survives clear");
    wr(5'd13, 32'h4);
    rd(5'd13, 32'h0, "R9 later clear works");

    // R10 mask
    pinIn[2] = 1'b0;
    idle(4);
    rd(5'd13, 32'h4, "R10 latched while masked");
    check("R10 irq masked", {31'd0, irqPending}, '0);
    wr(5'd15, 32'hFFFF_FFFF);
    check("R10 irq unmasked", {31'd0, irqPending}, 32'h1);
    rd(5'd14, 32'hFFFF_FFFF, "R10 mask all");
    wr(5'd16, 32'h4);
    check("R10 irq after mask clear", {31'd0, irqPending}, '0);
    wr(5'd15, 32'h4);
    check("R10 irq remask", {31'd0, irqPending}, 32'h1);
    wr(5'd13, 32'h4);
    check("R10 irq after status clear", {31'd0, irqPending}, '0);

    // R11 unmapped writes / reads
    wr(5'd31, 32'hFFFF_FFFF);
    wr(5'd20, 32'hFFFF_FFFF);
    rd(5'd1, 32'h0000_F000, "R11 dir unchanged");
    rd(5'd4, 32'h0F00_00C0, "R11 out unchanged");
    rd(5'd7, 32'h4, "R11 rise unchanged");
    rd(5'd10, 32'h6, "R11 fall unchanged");
    rd(5'd13, 32'h0, "R11 stat unchanged");
    rd(5'd31, 32'h0, "R11 unmapped read");
    rd(5'd5, 32'h0, "R11 write-only read");

    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule